// File: doc/BRIEF.md
# I2C Word-Register Slave Interface

This block is the serial front end of a device whose state is held in a small bank of 16-bit registers. It watches the open-drain SCL and SDA lines through synchronisers clocked by a much faster system clock. It finds start and stop conditions and answers to a 7-bit slave address. The upper bits of that address are a parameter and the low bits come from strap inputs, so several copies can share one bus. The single output `sda_oe` pulls SDA low. It is used for acknowledge bits and for read data.

Every write transfer first loads an 8-bit register pointer, which drives `reg_addr`. When two more bytes follow, the high byte first, they form one word. That word is committed with a single-cycle `reg_we` strobe. A read transfer returns the word at the pointer, high byte first. The pointer is not changed, so repeated reads need no new pointer. A transfer that stalls with no SCL edges for the timeout window is abandoned and SDA is released.

The state machine has these states. `ST_IDLE` waits for a start. `ST_ADDR` receives the address byte, then `ST_ADDR_ACK` follows on a match, or `ST_IDLE` on a mismatch. A write continues through `ST_PTR` → `ST_PTR_ACK` → `ST_DMSB` → `ST_MSB_ACK` → `ST_DLSB` → `ST_LSB_ACK` → `ST_IDLE`, and the strobe fires on leaving `ST_LSB_ACK`. A read goes from `ST_ADDR_ACK` to `ST_RD_DATA` → `ST_RD_MACK`. From `ST_RD_MACK` it returns to `ST_RD_DATA` on a master ACK, or goes to `ST_IDLE` on a NACK. Any state moves to `ST_ADDR` on a start, and to `ST_IDLE` on a stop or a timeout.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_addr` is 0x00. A stop condition (SDA rising while SCL is high) returns the block to idle.
- R2: A start condition is SDA falling while SCL is high. The following address byte is shifted in MSB first on rising SCL. Its bits 7:1 are compared with {ADDR_HI, strap_i}, and bit 0 is the direction (0 = write, 1 = read). On a match the block pulls SDA low in the ninth clock. On a mismatch it never drives SDA.
- R3: Every byte received in a write transfer (pointer byte and data bytes) is acknowledged by pulling SDA low in its ninth clock.
- R4: The first byte after a write address loads the pointer, which appears on `reg_addr`. A transfer that ends after this byte only sets the pointer.
- R5: Two data bytes after the pointer byte form one word, the first byte being bits 15:8. The word is presented on `reg_wdata` with `reg_we` high for exactly one cycle, after the second data byte's acknowledge.
- R6: A write transfer with zero or one data byte produces no `reg_we` strobe.
- R7: A read returns `reg_rdata[15:8]` and then `reg_rdata[7:0]` of the pointed register, MSB first. The pointer is kept, so a later read with no pointer write returns the same register.
- R8: When the master answers a read byte with NACK (SDA high in the ninth clock), the block stops driving SDA.
- R9: A repeated start during a transfer restarts address reception. It leaves the pointer unchanged and discards any incomplete word.
- R10: If a transfer in progress sees no SCL edge for CLK_HZ*TIMEOUT_MS/1000 system cycles, the block returns to idle and releases SDA.
- R11: The block begins pulling SDA low only while SCL is low, never while SCL is high.
- R12: Changing `strap_i` changes the address the block answers to. The old address is then no longer acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain drive) |
| strap_i | input | STRAP_W | Strap bits forming the low bits of the slave address |
| reg_addr | output | 8 | Current register pointer |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle word write strobe |
| reg_rdata | input | 16 | Word read from the register at `reg_addr` |

## Verification
The assertions check several rules on every cycle. Drive on SDA may only begin while the synchronised SCL is low. The write strobe is a single pulse and comes only out of the final acknowledge state. The pointer changes only on leaving the pointer-byte state. A stop always lands in idle, a master NACK always releases SDA, and the timeout counter stays below its limit. The bench scenarios are needed for the end-to-end facts that no single cycle shows. These include correct address matching under different straps, the byte order of written and read words, and pointer retention across transfers. They also cover the absence of a strobe for short writes and after a repeated start, and the release of a stalled read after the full timeout window.

// File: rtl/i2c_ws_pkg.sv
package i2c_ws_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DMSB,
        ST_MSB_ACK,
        ST_DLSB,
        ST_LSB_ACK,
        ST_RD_DATA,
        ST_RD_MACK
    } ws_state_e;

endpackage

// File: rtl/i2c_ws_sync.sv
module i2c_ws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // one extra stage past the synchroniser holds the previous sample
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_pipe;
    logic [PW-1:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[PW-2:0], scl_i};
            sda_pipe <= {sda_pipe[PW-2:0], sda_i};
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_prev = scl_pipe[STAGES];
    assign sda_prev = sda_pipe[STAGES];

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_ws_timeout.sv
module i2c_ws_timeout #(
    parameter int LIMIT = 1400000,
    localparam int CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic activity,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    assign expired = active && !activity && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || activity || expired) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R10
    tmo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT));

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2c_ws_pkg::*;
#(
    parameter int                  STRAP_W     = 2,
    parameter logic [6-STRAP_W:0]  ADDR_HI     = 5'h10,
    parameter int                  CLK_HZ      = 50_000_000,
    parameter int                  TIMEOUT_MS  = 28,
    parameter int                  SYNC_STAGES = 2,
    localparam int                 BYTE_W      = 8,
    localparam int                 WORD_W      = 2 * BYTE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [STRAP_W-1:0] strap_i,
    output logic [BYTE_W-1:0]  reg_addr,
    output logic [WORD_W-1:0]  reg_wdata,
    output logic               reg_we,
    input  logic [WORD_W-1:0]  reg_rdata
);
    localparam int TMO_CYC = int'((longint'(CLK_HZ) * TIMEOUT_MS) / 1000);
    localparam int BCW     = $clog2(BYTE_W + 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det, tmo;

    ws_state_e          state_q, state_d;
    logic [BCW-1:0]     bit_cnt_q;
    logic [BYTE_W-1:0]  shreg_q;
    logic [BYTE_W-1:0]  ptr_q;
    logic [BYTE_W-1:0]  msb_q;
    logic [BYTE_W-1:0]  tx_q;
    logic [WORD_W-1:0]  wdata_q;
    logic               rw_q, lsb_next_q, nack_q, we_q;
    logic               byte_done, addr_hit, rx_state, leave_lsb_ack;

    i2c_ws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_ws_timeout #(.LIMIT(TMO_CYC)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (state_q != ST_IDLE),
        .activity (scl_rise | scl_fall | start_det),
        .expired  (tmo)
    );

    assign byte_done = (bit_cnt_q == BCW'(BYTE_W));
    assign addr_hit  = (shreg_q[BYTE_W-1:1] == {ADDR_HI, strap_i});
    assign rx_state  = (state_q == ST_ADDR) || (state_q == ST_PTR) ||
                       (state_q == ST_DMSB) || (state_q == ST_DLSB);
    assign leave_lsb_ack = scl_fall && (state_q == ST_LSB_ACK) &&
                           !start_det && !stop_det && !tmo;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_det || tmo) begin
            state_d = ST_IDLE;
        end else if (start_det) begin
            state_d = ST_ADDR;
        end else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: state_d = rw_q ? ST_RD_DATA : ST_PTR;
                ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
                ST_PTR_ACK:  state_d = ST_DMSB;
                ST_DMSB:     if (byte_done) state_d = ST_MSB_ACK;
                ST_MSB_ACK:  state_d = ST_DLSB;
                ST_DLSB:     if (byte_done) state_d = ST_LSB_ACK;
                ST_LSB_ACK:  state_d = ST_IDLE;
                ST_RD_DATA:  if (byte_done) state_d = ST_RD_MACK;
                ST_RD_MACK:  state_d = nack_q ? ST_IDLE : ST_RD_DATA;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
            ptr_q      <= '0;
            msb_q      <= '0;
            tx_q       <= '0;
            wdata_q    <= '0;
            rw_q       <= 1'b0;
            lsb_next_q <= 1'b0;
            nack_q     <= 1'b1;
            we_q       <= 1'b0;
        end else begin
            we_q <= leave_lsb_ack;

            if (state_d != state_q || start_det) begin
                bit_cnt_q <= '0;
            end else if (scl_rise && (rx_state || state_q == ST_RD_DATA)) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
            end

            if (scl_rise && rx_state) shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};

            if (state_q == ST_ADDR && state_d == ST_ADDR_ACK) rw_q <= shreg_q[0];
            if (state_q == ST_PTR && state_d == ST_PTR_ACK)   ptr_q <= shreg_q;
            if (state_q == ST_DMSB && state_d == ST_MSB_ACK)  msb_q <= shreg_q;
            if (state_q == ST_DLSB && state_d == ST_LSB_ACK)  wdata_q <= {msb_q, shreg_q};

            if (state_q == ST_RD_MACK && scl_rise) nack_q <= sda_s;

            if (state_q == ST_ADDR_ACK && state_d == ST_RD_DATA) begin
                tx_q       <= reg_rdata[WORD_W-1:BYTE_W];
                lsb_next_q <= 1'b1;
            end else if (state_q == ST_RD_MACK && state_d == ST_RD_DATA) begin
                tx_q       <= lsb_next_q ? reg_rdata[BYTE_W-1:0] : reg_rdata[WORD_W-1:BYTE_W];
                lsb_next_q <= ~lsb_next_q;
            end else if (state_q == ST_RD_DATA && state_d == ST_RD_DATA && scl_fall) begin
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_PTR_ACK, ST_MSB_ACK, ST_LSB_ACK: sda_oe = 1'b1;
            ST_RD_DATA:                                      sda_oe = ~tx_q[BYTE_W-1];
            default:                                         sda_oe = 1'b0;
        endcase
    end

    assign reg_addr  = ptr_q;
    assign reg_wdata = wdata_q;
    assign reg_we    = we_q;

    // R11
    drv_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R5
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5
    we_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(state_q) == ST_LSB_ACK);

    // R4
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != $past(reg_addr)) |-> $past(state_q) == ST_PTR);

    // R1
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> state_q == ST_IDLE);

    // R8
    nack_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_MACK && scl_fall && nack_q) |=> !sda_oe);

endmodule

// File: tb/i2c_word_slave_tb_top.sv
module i2c_word_slave_tb_top;
    localparam int Q = 10;
    localparam int TB_CLK_HZ = 50_000;
    localparam int TMO = TB_CLK_HZ * 28 / 1000;

    typedef struct packed { logic [7:0] a; logic [15:0] d; } wr_t;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'b01;
    logic        sda_oe, reg_we;
    logic [7:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic [15:0] regs [0:255];
    wire         sda_line = sda_m & ~sda_oe;
    wire  [15:0] reg_rdata = regs[reg_addr];

    int n_chk = 0, n_fail = 0, viol = 0;
    bit prev_scl = 1'b1, prev_oe = 1'b0, done = 1'b0;
    wr_t exp_q[$];

    i2c_word_slave #(.CLK_HZ(TB_CLK_HZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(strap), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-clock reference: expected word writes and SDA drive timing
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", {reg_addr, reg_wdata}, 0);
                end else begin
                    wr_t e;
                    e = exp_q.pop_front();
                    chk({reg_addr, reg_wdata} == {e.a, e.d}, "R5 word write",
                        {reg_addr, reg_wdata}, {e.a, e.d});
                end
                regs[reg_addr] = reg_wdata;
            end
            if (scl_m && prev_scl && (sda_oe != prev_oe)) viol++;
            prev_scl = scl_m;
            prev_oe  = sda_oe;
        end
    end

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b0; tk(Q); scl_m = 1'b0; tk(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tk(Q); scl_m = 1'b1; tk(Q); sda_m = 1'b1; tk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tk(Q); scl_m = 1'b1; tk(Q); scl_m = 1'b0; tk(4);
        end
        sda_m = 1'b1; tk(Q); scl_m = 1'b1; tk(Q / 2);
        acked = (sda_line == 1'b0);
        tk(Q / 2); scl_m = 1'b0; tk(4);
    endtask

    task automatic recv_byte(input bit nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tk(Q); scl_m = 1'b1; tk(Q / 2); b[i] = sda_line; tk(Q / 2); scl_m = 1'b0; tk(4);
        end
        sda_m = nack; tk(Q); scl_m = 1'b1; tk(Q); scl_m = 1'b0; tk(4); sda_m = 1'b1;
    endtask

    task automatic report();
        chk(viol == 0, "R11 drive change while SCL high", viol, 0);
        chk(exp_q.size() == 0, "R5 missing strobe", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 0, 1);
            report();
        end
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) regs[i] = 16'(i * 3);
        regs[7] = 16'h1234;
        tk(5);
        chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_addr == 8'h00, "R1 reset state",
            {sda_oe, reg_we, reg_addr}, 0);
        rst_n = 1'b1;
        tk(5);

        // full word write to register 0x05
        exp_q.push_back('{a: 8'h05, d: 16'hA53C});
        bus_start();
        send_byte(8'h82, a); chk(a, "R2 address ack", a, 1);
        send_byte(8'h05, a); chk(a, "R3 pointer ack", a, 1);
        send_byte(8'hA5, a); chk(a, "R3 msb ack", a, 1);
        send_byte(8'h3C, a); chk(a, "R3 lsb ack", a, 1);
        bus_stop();
        chk(reg_addr == 8'h05, "R4 pointer on reg_addr", reg_addr, 8'h05);

        // read back, MSB then LSB
        bus_start();
        send_byte(8'h83, a); chk(a, "R2 read address ack", a, 1);
        recv_byte(1'b0, b); chk(b == 8'hA5, "R7 read msb", b, 8'hA5);
        recv_byte(1'b1, b); chk(b == 8'h3C, "R7 read lsb", b, 8'h3C);
        bus_stop();

        // pointer retained; NACK on MSB releases SDA
        bus_start();
        send_byte(8'h83, a);
        recv_byte(1'b1, b); chk(b == 8'hA5, "R7 repeated read", b, 8'hA5);
        chk(sda_oe == 1'b0, "R8 release after nack", sda_oe, 0);
        tk(Q); chk(sda_oe == 1'b0, "R8 still released", sda_oe, 0);
        bus_stop();

        // pointer-only write then read
        bus_start();
        send_byte(8'h82, a); send_byte(8'h07, a); chk(a, "R4 pointer-only ack", a, 1);
        bus_stop();
        bus_start();
        send_byte(8'h83, a);
        recv_byte(1'b0, b); chk(b == 8'h12, "R4 read new pointer msb", b, 8'h12);
        recv_byte(1'b1, b); chk(b == 8'h34, "R4 read new pointer lsb", b, 8'h34);
        bus_stop();

        // single data byte: no commit
        bus_start();
        send_byte(8'h82, a); send_byte(8'h05, a); send_byte(8'hFF, a);
        bus_stop();
        bus_start();
        send_byte(8'h83, a);
        recv_byte(1'b1, b); chk(b == 8'hA5, "R6 one data byte not written", b, 8'hA5);
        bus_stop();

        // wrong address
        bus_start();
        send_byte(8'h84, a); chk(!a, "R2 no ack on mismatch", a, 0);
        bus_stop();

        // strap change moves the address
        strap = 2'b10;
        tk(Q);
        exp_q.push_back('{a: 8'h09, d: 16'hBEEF});
        bus_start();
        send_byte(8'h84, a); chk(a, "R12 new address ack", a, 1);
        send_byte(8'h09, a); send_byte(8'hBE, a); send_byte(8'hEF, a);
        bus_stop();
        bus_start();
        send_byte(8'h82, a); chk(!a, "R12 old address ignored", a, 0);
        bus_stop();

        // repeated start mid-word
        bus_start();
        send_byte(8'h84, a); send_byte(8'h07, a); send_byte(8'h55, a);
        bus_start();
        send_byte(8'h85, a); chk(a, "R9 address after repeated start", a, 1);
        recv_byte(1'b0, b); chk(b == 8'h12, "R9 pointer kept msb", b, 8'h12);
        recv_byte(1'b1, b); chk(b == 8'h34, "R9 pointer kept lsb", b, 8'h34);
        bus_stop();

        // stall in read: timeout releases SDA
        bus_start();
        send_byte(8'h85, a);
        tk(50);
        chk(sda_oe == 1'b1, "R10 driving before timeout", sda_oe, 1);
        tk(TMO + 100);
        chk(sda_oe == 1'b0, "R10 released after timeout", sda_oe, 0);
        bus_stop();
        tk(20);

        done = 1'b1;
        report();
    end
endmodule